// File: doc/BRIEF.md
# Luma Contrast Enhancement Unit

This unit reshapes the luminance of a pixel stream with one of eight fixed linear curves. Three curves subtract a black offset and then apply gain, which deepens dark tones. One curve passes luma through unchanged. Four curves apply gain with no offset, which brightens the picture. Every gain is one plus a power-of-two fraction, so the datapath is one subtract, one shift and one add, with saturation. There are no multipliers.

The incoming sample carries a valid flag, an 8-bit Y value and a chroma word. Chroma is not altered. It is delayed so that it leaves with the luma it arrived with. A 3-bit curve select is sampled only on a line-start strobe, so a curve change can never split a line. The pipeline has a fixed depth of two clocks.

Top module: `luma_contrast`

## Requirements
- R1: While reset is asserted and after it is released, out_valid_o, y_o and c_o are 0. The active curve is the identity (code 3) until the first line_start_i.
- R2: y_o and out_valid_o show the result for the sample presented two rising clock edges earlier, with a fixed latency of 2 clocks.
- R3: c_o equals c_i from two clocks earlier. This holds whatever the value of valid_i.
- R4: Codes 0, 1 and 2 give floor(5/4·(Y−102)), floor(9/8·(Y−57)) and floor(17/16·(Y−30)), in that order. A negative difference gives 0.
- R5: Code 3 gives Y unchanged.
- R6: Codes 4, 5, 6 and 7 give floor(17/16·Y), floor(9/8·Y), floor(5/4·Y) and floor(3/2·Y), in that order. A result above 255 saturates to 255.
- R7: Fractional bits are truncated toward zero. Examples: code 7 with Y=3 gives 4, and code 4 with Y=15 gives 15.
- R8: When line_start_i is high, sel_i becomes the active curve, and that same cycle's sample already uses it. This happens whatever the value of valid_i. When line_start_i is low, changes on sel_i have no effect on the output.
- R9: Under every code, every one of the 256 input values gives the curve value given by R4 to R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input sample is valid |
| y_i | input | 8 | Input luma |
| c_i | input | C_W | Input chroma word |
| line_start_i | input | 1 | Line boundary strobe; loads the curve select |
| sel_i | input | 3 | Requested curve code |
| out_valid_o | output | 1 | Output sample is valid |
| y_o | output | 8 | Enhanced, clamped luma |
| c_o | output | C_W | Chroma, delayed to match y_o |

## Verification
The embedded properties check the following on every cycle:
- the two-clock alignment of valid and chroma;
- that the active select holds between line strobes;
- that black curves floor to zero below their offset;
- that white curves never darken;
- that the strongest curve saturates.

The exact value of every curve point needs the bench's independent curve model. This covers the full 256-by-8 sweep, the truncation and clamp corners, and the proof that a mid-line change on sel_i leaves the output on the old curve.

// File: rtl/luma_contrast_pkg.sv
package luma_contrast_pkg;
  localparam int unsigned Y_W   = 8;
  localparam int unsigned SEL_W = 3;
  localparam logic [SEL_W-1:0] SEL_IDENTITY = 3'd3;

  typedef logic [Y_W-1:0]   luma_t;
  typedef logic [SEL_W-1:0] curve_sel_t;

  typedef struct packed {
    luma_t      offset;
    logic [2:0] shift;
    logic       add_en;
    logic       white;
  } curve_cfg_t;

  // gain = 1 + 2^-shift when add_en
  function automatic curve_cfg_t curve_cfg(input curve_sel_t sel);
    curve_cfg_t c;
    c = '{offset: '0, shift: 3'd0, add_en: 1'b0, white: 1'b0};
    case (sel)
      3'd0: c = '{offset: 8'd102, shift: 3'd2, add_en: 1'b1, white: 1'b0};
      3'd1: c = '{offset: 8'd57,  shift: 3'd3, add_en: 1'b1, white: 1'b0};
      3'd2: c = '{offset: 8'd30,  shift: 3'd4, add_en: 1'b1, white: 1'b0};
      3'd3: c = '{offset: 8'd0,   shift: 3'd0, add_en: 1'b0, white: 1'b0};
      3'd4: c = '{offset: 8'd0,   shift: 3'd4, add_en: 1'b1, white: 1'b1};
      3'd5: c = '{offset: 8'd0,   shift: 3'd3, add_en: 1'b1, white: 1'b1};
      3'd6: c = '{offset: 8'd0,   shift: 3'd2, add_en: 1'b1, white: 1'b1};
      default: c = '{offset: 8'd0, shift: 3'd1, add_en: 1'b1, white: 1'b1};
    endcase
    return c;
  endfunction
endpackage

// File: rtl/curve_sel_hold.sv
module curve_sel_hold
  import luma_contrast_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       line_start_i,
  input  curve_sel_t sel_i,
  output curve_sel_t sel_o
);
  curve_sel_t sel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           sel_q <= SEL_IDENTITY;
    else if (line_start_i) sel_q <= sel_i;
  end

  // new code applies to the strobe cycle's own sample
  assign sel_o = line_start_i ? sel_i : sel_q;

  AST_SEL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !line_start_i |=> $stable(sel_q)); // R8
endmodule

// File: rtl/luma_offset_stage.sv
module luma_offset_stage
  import luma_contrast_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       valid_i,
  input  luma_t      y_i,
  input  curve_sel_t sel_i,
  output logic       valid_o,
  output luma_t      d_o,
  output curve_sel_t sel_o
);
  curve_cfg_t cfg;
  luma_t      d_d;

  always_comb begin
    cfg = curve_cfg(sel_i);
    d_d = (y_i > cfg.offset) ? luma_t'(y_i - cfg.offset) : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      d_o     <= '0;
      sel_o   <= SEL_IDENTITY;
    end else begin
      valid_o <= valid_i;
      d_o     <= d_d;
      sel_o   <= sel_i;
    end
  end

  AST_BLACK_FLOOR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && sel_i < 3'd3 && y_i <= curve_cfg(sel_i).offset) |=> d_o == '0); // R4
endmodule

// File: rtl/luma_gain_stage.sv
module luma_gain_stage
  import luma_contrast_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       valid_i,
  input  luma_t      d_i,
  input  curve_sel_t sel_i,
  output logic       valid_o,
  output luma_t      y_o
);
  localparam int unsigned SUM_W = Y_W + 1;

  curve_cfg_t       cfg;
  logic [SUM_W-1:0] sum;
  luma_t            y_d;

  always_comb begin
    cfg = curve_cfg(sel_i);
    sum = {1'b0, d_i} + (cfg.add_en ? {1'b0, d_i >> cfg.shift} : '0);
    y_d = sum[SUM_W-1] ? '1 : sum[Y_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      y_o     <= '0;
    end else begin
      valid_o <= valid_i;
      y_o     <= y_d;
    end
  end

  AST_WHITE_NOT_DARKER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && cfg.white) |=> y_o >= $past(d_i)); // R6
  AST_TOP_SATURATES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && sel_i == 3'd7 && d_i >= 8'd171) |=> y_o == 8'hFF); // R6
endmodule

// File: rtl/delay_line.sv
module delay_line #(
  parameter int unsigned W     = 16,
  parameter int unsigned DEPTH = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] tap [DEPTH+1];

  assign tap[0] = d_i;

  for (genvar i = 0; i < DEPTH; i++) begin : g_tap
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) tap[i+1] <= '0;
      else         tap[i+1] <= tap[i];
    end
  end

  assign q_o = tap[DEPTH];
endmodule

// File: rtl/luma_contrast.sv
module luma_contrast
  import luma_contrast_pkg::*;
#(
  parameter int unsigned C_W = 16
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           valid_i,
  input  logic [7:0]     y_i,
  input  logic [C_W-1:0] c_i,
  input  logic           line_start_i,
  input  logic [2:0]     sel_i,
  output logic           out_valid_o,
  output logic [7:0]     y_o,
  output logic [C_W-1:0] c_o
);
  localparam int unsigned LATENCY = 2;

  curve_sel_t sel_eff, sel_s1;
  logic       valid_s1;
  luma_t      d_s1;

  curve_sel_hold u_sel (
    .clk_i, .rst_ni, .line_start_i, .sel_i, .sel_o(sel_eff)
  );

  luma_offset_stage u_off (
    .clk_i, .rst_ni, .valid_i, .y_i, .sel_i(sel_eff),
    .valid_o(valid_s1), .d_o(d_s1), .sel_o(sel_s1)
  );

  luma_gain_stage u_gain (
    .clk_i, .rst_ni, .valid_i(valid_s1), .d_i(d_s1), .sel_i(sel_s1),
    .valid_o(out_valid_o), .y_o
  );

  delay_line #(.W(C_W), .DEPTH(LATENCY)) u_cdly (
    .clk_i, .rst_ni, .d_i(c_i), .q_o(c_o)
  );

  // cycles since reset, for history-safe checks
  logic [1:0] age_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            age_q <= '0;
    else if (age_q != 2'd3) age_q <= age_q + 2'd1;
  end

  AST_VALID_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    age_q >= 2'd2 |-> out_valid_o == $past(valid_i, 2)); // R2
  AST_CHROMA_ALIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    age_q >= 2'd2 |-> c_o == $past(c_i, 2)); // R3
  AST_IDENTITY_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q >= 2'd2 && $past(valid_i, 2) && $past(sel_eff, 2) == SEL_IDENTITY)
      |-> y_o == $past(y_i, 2)); // R5
endmodule

// File: tb/luma_contrast_test.sv
module luma_contrast_test;
  localparam int C_W = 16;

  logic           clk_i = 1'b0;
  logic           rst_ni = 1'b0;
  logic           valid_i = 1'b0;
  logic [7:0]     y_i = '0;
  logic [C_W-1:0] c_i = '0;
  logic           line_start_i = 1'b0;
  logic [2:0]     sel_i = '0;
  logic           out_valid_o;
  logic [7:0]     y_o;
  logic [C_W-1:0] c_o;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // bench-side model state
  logic [2:0]     bsel;
  logic           ev0, ev1;
  logic [7:0]     ey0, ey1;
  logic [C_W-1:0] ec0, ec1;
  string          er0, er1;

  always #10 clk_i = ~clk_i;

  luma_contrast #(.C_W(C_W)) uut (.*);

  function automatic int ref_curve(input int s, input int y);
    int d, r;
    case (s)
      0: begin d = y - 102; r = (d < 0) ? 0 : (d * 5) / 4;  end
      1: begin d = y - 57;  r = (d < 0) ? 0 : (d * 9) / 8;  end
      2: begin d = y - 30;  r = (d < 0) ? 0 : (d * 17) / 16; end
      3: r = y;
      4: r = (y * 17) / 16;
      5: r = (y * 9) / 8;
      6: r = (y * 5) / 4;
      default: r = (y * 3) / 2;
    endcase
    return (r > 255) ? 255 : r;
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // one clock: compare the sample from two steps back, then drive a new one
  task automatic step(input logic v, input logic [7:0] y, input logic [C_W-1:0] c,
                      input logic ls, input logic [2:0] s, input string req);
    @(negedge clk_i);
    check("R2", "valid", out_valid_o, ev1);
    check("R3", "chroma", c_o, ec1);
    if (ev1) check(er1, "luma", y_o, ey1);
    ev1 = ev0; ey1 = ey0; ec1 = ec0; er1 = er0;
    if (ls) bsel = s;
    ev0 = v; ec0 = c; er0 = req;
    ey0 = 8'(ref_curve(int'(bsel), int'(y)));
    valid_i = v; y_i = y; c_i = c; line_start_i = ls; sel_i = s;
  endtask

  task automatic drain();
    for (int i = 0; i < 3; i++) step(1'b0, 8'd0, 16'h0, 1'b0, bsel, "R2");
  endtask

  task automatic test_reset();
    bsel = 3'd3;
    ev0 = 0; ev1 = 0; ey0 = 0; ey1 = 0; ec0 = 0; ec1 = 0; er0 = "R1"; er1 = "R1";
    rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    check("R1", "valid in reset", out_valid_o, 0);
    check("R1", "luma in reset", y_o, 0);
    check("R1", "chroma in reset", c_o, 0);
    rst_ni = 1'b1;
    // R1: identity is active with no line strobe yet
    step(1'b1, 8'd200, 16'h1234, 1'b0, 3'd0, "R1");
    step(1'b1, 8'd10, 16'h5678, 1'b0, 3'd7, "R1");
    drain();
  endtask

  task automatic test_sweep();
    for (int s = 0; s < 8; s++)
      for (int y = 0; y < 256; y++)
        step(1'b1, 8'(y), 16'(y * 7 + s), y == 0, 3'(s), "R9");
    drain();
  endtask

  task automatic test_corners();
    step(1'b1, 8'd102, 16'h1, 1'b1, 3'd0, "R4"); // floor at offset
    step(1'b1, 8'd0,   16'h2, 1'b0, 3'd0, "R4");
    step(1'b1, 8'd255, 16'h3, 1'b0, 3'd0, "R4"); // 191
    step(1'b1, 8'd57,  16'h4, 1'b1, 3'd1, "R4");
    step(1'b1, 8'd29,  16'h5, 1'b1, 3'd2, "R4");
    step(1'b1, 8'd255, 16'h6, 1'b1, 3'd3, "R5");
    step(1'b1, 8'd0,   16'h7, 1'b0, 3'd3, "R5");
    step(1'b1, 8'd170, 16'h8, 1'b1, 3'd7, "R6"); // exactly 255
    step(1'b1, 8'd171, 16'h9, 1'b0, 3'd7, "R6"); // clamp
    step(1'b1, 8'd241, 16'hA, 1'b1, 3'd4, "R6"); // 256 -> 255
    step(1'b1, 8'd3,   16'hB, 1'b1, 3'd7, "R7"); // 4
    step(1'b1, 8'd15,  16'hC, 1'b1, 3'd4, "R7"); // 15
    step(1'b1, 8'd7,   16'hD, 1'b1, 3'd6, "R7"); // 8
    drain();
  endtask

  task automatic test_sel_hold();
    step(1'b1, 8'd100, 16'h11, 1'b1, 3'd7, "R8");
    for (int i = 0; i < 6; i++)                   // sel_i moves without strobe
      step(1'b1, 8'(60 + i * 20), 16'(i), 1'b0, 3'(i), "R8");
    step(1'b0, 8'd0, 16'h22, 1'b1, 3'd0, "R8");   // strobe with valid low still loads
    step(1'b1, 8'd200, 16'h33, 1'b0, 3'd5, "R8");
    step(1'b1, 8'd90, 16'h44, 1'b0, 3'd6, "R8");
    drain();
  endtask

  task automatic test_gaps();
    for (int i = 0; i < 40; i++)
      step(i % 3 != 0, 8'(i * 13), 16'(16'hA5A5 ^ i), i == 5, 3'd5, "R3");
    drain();
  endtask

  initial begin
    test_reset();
    test_corners();
    test_sel_hold();
    test_gaps();
    test_sweep();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule